// File: doc/BRIEF.md
# Table-Driven Wormhole Next-Hop Router Stage

This block is the routing stage of a network-on-chip switch whose links form an irregular topology. Every input port presents one flit at a time. When a packet's header arrives, its destination ID is looked up in a next-hop table that was written beforehand. The table gives an output port. The header's layer field picks the virtual channel on that port, with one channel for each routing layer. The header then reserves that output/channel pair. Body flits and the tail flit of the same packet carry no routing data of their own: they follow the reserved path. The tail frees the reservation as it passes.

Flit format (FLIT_W = 32):
- Type code in the top two bits [31:30]: 00 body, 01 header, 10 tail, 11 single-flit packet.
- Destination ID in bits [5:0].
- Layer in bits [7:6].
- The remaining bits are payload and pass through unchanged.

Each output port carries at most one flit per cycle. When several inputs want the same port, a fixed priority decides: the lowest input index wins. An accepted flit appears on its output port one clock after the cycle in which `in_ready_o` was high for it. Software-side loading of the table uses a single write port. That port only takes effect while no input holds a reserved path.

Top module: `rt_wormhole_router`

## Requirements
- R1: After reset, no output is valid and every table entry is port 0. A single-flit packet sent then leaves on port 0.
- R2: A table write while no path is held sets the entry for `tbl_dest_i` to `tbl_port_i`. The change is visible to headers from the next cycle on.
- R3: A header (type 01) or single-flit packet (type 11) that is accepted appears one cycle later, unchanged, on the port that the table holds for dest[5:0]. Its `out_vc_o` equals the layer field, flit bits [7:6].
- R4: Once a header is accepted, that input's body (00) and tail (10) flits go to the header's port and channel. Their own destination and layer bits are ignored. A tail (or a type 11 flit) on a held path releases the path.
- R5: A header whose output/channel pair is reserved by another packet is not accepted (`in_ready_o` low). It is accepted in the cycle after the holder's tail is accepted.
- R6: Packets on different layers to the same output port hold separate channels at the same time. Their flits interleave on that port.
- R7: When several eligible inputs target one output port in a cycle, only the lowest-indexed input is accepted. The others wait.
- R8: A single-flit packet needs its output/channel pair to be free. It reserves nothing, so identical single-flit packets are accepted in back-to-back cycles.
- R9: A table write issued while any input holds a path is ignored. The entry keeps its old value after the path is released.
- R10: A body or tail flit on an input with no held path is not accepted and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_dest_i | input | DEST_W | Table entry (destination ID) to write |
| tbl_port_i | input | PORT_W | Next-hop output port to store |
| in_valid_i | input | NUM_PORTS | Flit present, one bit per input |
| in_flit_i | input | NUM_PORTS*FLIT_W | Input flits, input i at [i*FLIT_W +: FLIT_W] |
| in_ready_o | output | NUM_PORTS | Flit accepted this cycle, per input |
| out_valid_o | output | NUM_PORTS | Flit leaving, per output port |
| out_flit_o | output | NUM_PORTS*FLIT_W | Outgoing flits, per output port |
| out_vc_o | output | NUM_PORTS*VC_W | Virtual channel of the outgoing flit |

## Verification
Some internal faults show up at the ports on the very next edge. A stale or wrongly written table entry sends the flit out on the wrong `out_valid_o` bit. A lost held path sends the next body flit where its own destination bits point. A reservation that is never cleared shows up more slowly: a later header on the same layer and port sees `in_ready_o` stay low for good. A spurious reservation behaves the same way. A reservation that is set too eagerly also blocks single-flit packets on that layer. The bench sweeps every destination and layer through the table and walks through each blocking and release order, so each of these faults appears within a few cycles of the stimulus that exposes it.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flit_type_e;
endpackage

// File: rtl/rt_next_hop_table.sv
module rt_next_hop_table #(
  parameter int DEST_W = 6,
  parameter int PORT_W = 4,
  parameter int NUM_RD = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     block_i,
  input  logic [DEST_W-1:0]        wr_dest_i,
  input  logic [PORT_W-1:0]        wr_port_i,
  input  logic [NUM_RD*DEST_W-1:0] rd_dest_i,
  output logic [NUM_RD*PORT_W-1:0] rd_port_o
);
  localparam int NUM_DEST = 1 << DEST_W;

  logic [NUM_DEST-1:0][PORT_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i && !block_i) mem_q[wr_dest_i] <= wr_port_i;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_port_o[r*PORT_W +: PORT_W] = mem_q[rd_dest_i[r*DEST_W +: DEST_W]];
  end

  AST_TBL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && block_i) |=> (mem_q == $past(mem_q))); // R9
  AST_TBL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !block_i) |=> (mem_q[$past(wr_dest_i)] == $past(wr_port_i))); // R2
endmodule

// File: rtl/rt_fixed_prio_arb.sv
module rt_fixed_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_input_path.sv
module rt_input_path
  import rt_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int VC_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [1:0]        ftype_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [VC_W-1:0]   vc_i,
  output logic              hold_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VC_W-1:0]   vc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      port_o <= '0;
      vc_o   <= '0;
    end else if (accept_i) begin
      if (!hold_o && ftype_i == FT_HEAD) begin
        hold_o <= 1'b1;
        port_o <= port_i;
        vc_o   <= vc_i;
      end else if (hold_o && ftype_i[1]) begin
        hold_o <= 1'b0; // tail or single code closes the path
      end
    end
  end

  AST_PATH_PINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(hold_o)) |-> ($stable(port_o) && $stable(vc_o))); // R4
  AST_NO_STRAY_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !hold_o) |-> ftype_i[0]); // R10
endmodule

// File: rtl/rt_wormhole_router.sv
module rt_wormhole_router
  import rt_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VC    = 4,
  parameter int DEST_W    = 6,
  parameter int PORT_W    = 4,
  parameter int FLIT_W    = 32,
  localparam int VC_W     = $clog2(NUM_VC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tbl_we_i,
  input  logic [DEST_W-1:0]           tbl_dest_i,
  input  logic [PORT_W-1:0]           tbl_port_i,
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  input  logic [NUM_PORTS*FLIT_W-1:0] in_flit_i,
  output logic [NUM_PORTS-1:0]        in_ready_o,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  output logic [NUM_PORTS*FLIT_W-1:0] out_flit_o,
  output logic [NUM_PORTS*VC_W-1:0]   out_vc_o
);
  localparam int NUM_LOCK  = NUM_PORTS * NUM_VC;
  localparam int LAYER_LSB = DEST_W;

  logic [NUM_PORTS-1:0][FLIT_W-1:0] flit_w;
  logic [NUM_PORTS*DEST_W-1:0]      rd_dest;
  logic [NUM_PORTS*PORT_W-1:0]      rd_port;
  logic [NUM_PORTS-1:0]             hold, elig, accept;
  logic [1:0]                       ftype    [NUM_PORTS];
  logic [PORT_W-1:0]                hold_port[NUM_PORTS];
  logic [VC_W-1:0]                  hold_vc  [NUM_PORTS];
  logic [PORT_W-1:0]                req_port [NUM_PORTS];
  logic [VC_W-1:0]                  req_vc   [NUM_PORTS];
  int                               req_idx  [NUM_PORTS];
  int                               hold_idx [NUM_PORTS];
  logic [NUM_LOCK-1:0]              lock_q, lock_d;

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] gnt_mat;
  logic [NUM_PORTS-1:0]                oval_d, oval_q;
  logic [NUM_PORTS-1:0][FLIT_W-1:0]    oflit_d, oflit_q;
  logic [NUM_PORTS-1:0][VC_W-1:0]      ovc_d, ovc_q;

  assign flit_w = in_flit_i;

  rt_next_hop_table #(.DEST_W(DEST_W), .PORT_W(PORT_W), .NUM_RD(NUM_PORTS)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .block_i   (|hold),
    .wr_dest_i (tbl_dest_i),
    .wr_port_i (tbl_port_i),
    .rd_dest_i (rd_dest),
    .rd_port_o (rd_port)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    logic in_rng, busy;

    assign ftype[i]  = flit_w[i][FLIT_W-1 -: 2];
    assign rd_dest[i*DEST_W +: DEST_W] = flit_w[i][DEST_W-1:0];
    assign req_port[i] = hold[i] ? hold_port[i] : rd_port[i*PORT_W +: PORT_W];
    assign req_vc[i]   = hold[i] ? hold_vc[i]   : flit_w[i][LAYER_LSB +: VC_W];
    assign req_idx[i]  = int'(req_port[i]) * NUM_VC + int'(req_vc[i]);
    assign hold_idx[i] = int'(hold_port[i]) * NUM_VC + int'(hold_vc[i]);
    assign in_rng = {1'b0, req_port[i]} < (PORT_W+1)'(NUM_PORTS);

    always_comb begin
      busy = 1'b1;
      if (in_rng) begin
        for (int k = 0; k < NUM_LOCK; k++) begin
          if (k == req_idx[i]) busy = lock_q[k];
        end
      end
    end

    // held path always eligible; new header needs a free in-range pair
    assign elig[i] = in_valid_i[i] && (hold[i] || (ftype[i][0] && in_rng && !busy));

    rt_input_path #(.PORT_W(PORT_W), .VC_W(VC_W)) u_path (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept[i]),
      .ftype_i  (ftype[i]),
      .port_i   (req_port[i]),
      .vc_i     (req_vc[i]),
      .hold_o   (hold[i]),
      .port_o   (hold_port[i]),
      .vc_o     (hold_vc[i])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    logic [NUM_PORTS-1:0] req_v, gnt_v;

    always_comb begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        req_v[i] = elig[i] && (req_port[i] == PORT_W'(p));
      end
    end

    rt_fixed_prio_arb #(.N(NUM_PORTS)) u_arb (
      .req_i (req_v),
      .gnt_o (gnt_v)
    );

    assign gnt_mat[p] = gnt_v;
    assign oval_d[p]  = |gnt_v;

    always_comb begin
      oflit_d[p] = '0;
      ovc_d[p]   = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (gnt_v[i]) begin
          oflit_d[p] = flit_w[i];
          ovc_d[p]   = req_vc[i];
        end
      end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_v)); // R7
    AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((gnt_v & ~req_v) == '0)); // R7
  end

  always_comb begin
    accept = '0;
    for (int p = 0; p < NUM_PORTS; p++) accept = accept | gnt_mat[p];
  end
  assign in_ready_o = accept;

  always_comb begin
    lock_d = lock_q;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (accept[i]) begin
        for (int k = 0; k < NUM_LOCK; k++) begin
          if (!hold[i] && ftype[i] == FT_HEAD && k == req_idx[i]) lock_d[k] = 1'b1;
          if (hold[i] && ftype[i][1] && k == hold_idx[i]) lock_d[k] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= '0;
      oval_q  <= '0;
      oflit_q <= '0;
      ovc_q   <= '0;
    end else begin
      lock_q  <= lock_d;
      oval_q  <= oval_d;
      oflit_q <= oflit_d;
      ovc_q   <= ovc_d;
    end
  end

  assign out_valid_o = oval_q;
  assign out_flit_o  = oflit_q;
  assign out_vc_o    = ovc_q;

  for (genvar k = 0; k < NUM_LOCK; k++) begin : g_lock_chk
    logic [NUM_PORTS-1:0] owner_v;
    always_comb begin
      for (int i = 0; i < NUM_PORTS; i++) owner_v[i] = hold[i] && (hold_idx[i] == k);
    end
    AST_LOCK_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(owner_v) == (lock_q[k] ? 1 : 0))); // R5
  end
endmodule

// File: tb/tb_rt_wormhole_router.sv
module tb_rt_wormhole_router;
  localparam int NP = 5;
  localparam int FW = 32;
  localparam int VW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tbl_we = 1'b0;
  logic [5:0]      tbl_dest = '0;
  logic [3:0]      tbl_port = '0;
  logic [NP-1:0]   in_valid = '0;
  logic [NP*FW-1:0] in_flit = '0;
  logic [NP-1:0]   ready, out_valid;
  logic [NP*FW-1:0] out_flit;
  logic [NP*VW-1:0] out_vc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rt_wormhole_router dut (
    .clk_i (clk), .rst_ni (rst_n),
    .tbl_we_i (tbl_we), .tbl_dest_i (tbl_dest), .tbl_port_i (tbl_port),
    .in_valid_i (in_valid), .in_flit_i (in_flit), .in_ready_o (ready),
    .out_valid_o (out_valid), .out_flit_o (out_flit), .out_vc_o (out_vc)
  );

  function automatic logic [31:0] mk(logic [1:0] t, int dest, int layer, int pay);
    logic [21:0] pl;
    pl = 22'(pay);
    return {t, pl, 2'(layer), 6'(dest)};
  endfunction

  function automatic int port_of(int d);
    return (d * 3 + 1) % 5;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_in(int i, bit v, logic [31:0] f);
    in_valid[i] = v;
    in_flit[i*FW +: FW] = f;
  endtask

  task automatic clr();
    in_valid = '0;
  endtask

  task automatic chk_ready(string req, logic [NP-1:0] exp);
    #1;
    chk({req, " ready"}, 64'(ready), 64'(exp));
  endtask

  task automatic chk_out(string req, int p, logic [31:0] f, int vc);
    chk({req, " out_valid"}, 64'(out_valid), 64'(1 << p));
    chk({req, " out_flit"}, 64'(out_flit[p*FW +: FW]), 64'(f));
    chk({req, " out_vc"}, 64'(out_vc[p*VW +: VW]), 64'(vc));
  endtask

  task automatic chk_none(string req);
    chk({req, " no output"}, 64'(out_valid), 64'(0));
  endtask

  task automatic wr_tbl(int d, int p);
    tbl_we = 1'b1; tbl_dest = 6'(d); tbl_port = 4'(p);
    tick();
    tbl_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] f, g;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset", 64'(out_valid), 64'(0));
    chk("R1 reset ready", 64'(ready), 64'(0));
    rst_n = 1'b1;
    tick();
    f = mk(2'b11, 9, 2, 7);
    set_in(1, 1'b1, f);
    chk_ready("R1", 5'b00010);
    tick();
    chk_out("R1 default entry", 0, f, 2);
    clr();

    // R2/R3: program and sweep every destination and layer
    for (int d = 0; d < 64; d++) wr_tbl(d, port_of(d));
    for (int d = 0; d < 64; d++) begin
      f = mk(2'b11, d, d % 4, d * 17 + 3);
      clr();
      set_in(d % NP, 1'b1, f);
      chk_ready("R3", 5'(1 << (d % NP)));
      tick();
      chk_out("R2 R3 sweep", port_of(d), f, d % 4);
    end
    clr();

    // R4: body and tail follow the header
    f = mk(2'b01, 10, 1, 1);
    set_in(2, 1'b1, f); chk_ready("R4", 5'b00100); tick();
    chk_out("R4 head", 1, f, 1);
    f = mk(2'b00, 11, 3, 2);
    set_in(2, 1'b1, f); chk_ready("R4", 5'b00100); tick();
    chk_out("R4 body", 1, f, 1);
    f = mk(2'b10, 0, 0, 3);
    set_in(2, 1'b1, f); chk_ready("R4", 5'b00100); tick();
    chk_out("R4 tail", 1, f, 1);
    clr();
    f = mk(2'b01, 10, 1, 4);
    set_in(3, 1'b1, f); chk_ready("R4 released", 5'b01000); tick();
    chk_out("R4 reuse", 1, f, 1);
    f = mk(2'b10, 0, 0, 5);
    set_in(3, 1'b1, f); tick();
    chk_out("R4 tail2", 1, f, 1);
    clr();

    // R5: header blocked by a held pair
    f = mk(2'b01, 10, 1, 6);
    set_in(0, 1'b1, f); tick();
    chk_out("R5 holder head", 1, f, 1);
    clr();
    g = mk(2'b01, 15, 1, 7);
    set_in(4, 1'b1, g); chk_ready("R5 blocked", 5'b00000); tick();
    chk_none("R5 blocked");
    f = mk(2'b00, 0, 0, 8);
    set_in(0, 1'b1, f); chk_ready("R5 body", 5'b00001); tick();
    chk_out("R5 body", 1, f, 1);
    f = mk(2'b10, 0, 0, 9);
    set_in(0, 1'b1, f); chk_ready("R5 tail cycle", 5'b00001); tick();
    chk_out("R5 tail", 1, f, 1);
    set_in(0, 1'b0, f);
    chk_ready("R5 after tail", 5'b10000); tick();
    chk_out("R5 waiter", 1, g, 1);
    f = mk(2'b10, 0, 0, 10);
    set_in(4, 1'b1, f); tick();
    chk_out("R5 waiter tail", 1, f, 1);
    clr();

    // R6/R7: two layers share port 1
    f = mk(2'b01, 10, 2, 11);
    g = mk(2'b01, 15, 3, 12);
    set_in(1, 1'b1, f); set_in(3, 1'b1, g);
    chk_ready("R7 priority", 5'b00010); tick();
    chk_out("R7 head", 1, f, 2);
    f = mk(2'b00, 0, 0, 13);
    set_in(1, 1'b1, f); chk_ready("R7 priority body", 5'b00010); tick();
    chk_out("R7 body", 1, f, 2);
    set_in(1, 1'b0, f); chk_ready("R6 second layer", 5'b01000); tick();
    chk_out("R6 head", 1, g, 3);
    f = mk(2'b00, 0, 0, 14);
    g = mk(2'b00, 0, 0, 15);
    set_in(1, 1'b1, f); set_in(3, 1'b1, g);
    chk_ready("R6 interleave", 5'b00010); tick();
    chk_out("R6 body vc2", 1, f, 2);
    set_in(1, 1'b0, f); chk_ready("R6 interleave", 5'b01000); tick();
    chk_out("R6 body vc3", 1, g, 3);
    f = mk(2'b10, 0, 0, 16);
    g = mk(2'b10, 0, 0, 17);
    set_in(1, 1'b1, f); set_in(3, 1'b1, g);
    chk_ready("R6 tails", 5'b00010); tick();
    chk_out("R6 tail vc2", 1, f, 2);
    set_in(1, 1'b0, f); chk_ready("R6 tails", 5'b01000); tick();
    chk_out("R6 tail vc3", 1, g, 3);
    clr();

    // R8: single-flit packets
    f = mk(2'b01, 10, 0, 18);
    set_in(0, 1'b1, f); tick();
    chk_out("R8 holder", 1, f, 0);
    clr();
    f = mk(2'b11, 15, 0, 19);
    set_in(2, 1'b1, f); chk_ready("R8 single blocked", 5'b00000); tick();
    chk_none("R8 single blocked");
    f = mk(2'b11, 15, 1, 20);
    set_in(2, 1'b1, f); chk_ready("R8 single free", 5'b00100); tick();
    chk_out("R8 single", 1, f, 1);
    chk_ready("R8 no reservation", 5'b00100); tick();
    chk_out("R8 single again", 1, f, 1);
    clr();

    // R9: write ignored while input 0 holds
    wr_tbl(20, 4);
    f = mk(2'b11, 20, 2, 21);
    set_in(1, 1'b1, f); chk_ready("R9", 5'b00010); tick();
    chk_out("R9 old entry", 1, f, 2);
    clr();
    f = mk(2'b10, 0, 0, 22);
    set_in(0, 1'b1, f); tick();
    chk_out("R9 release", 1, f, 0);
    clr();
    f = mk(2'b11, 20, 2, 23);
    set_in(1, 1'b1, f); tick();
    chk_out("R9 entry kept", 1, f, 2);
    clr();
    wr_tbl(20, 4);
    f = mk(2'b11, 20, 2, 24);
    set_in(1, 1'b1, f); tick();
    chk_out("R2 idle write", 4, f, 2);
    clr();

    // R10: stray body/tail
    f = mk(2'b00, 5, 0, 25);
    set_in(3, 1'b1, f); chk_ready("R10 body", 5'b00000); tick();
    chk_none("R10 body");
    f = mk(2'b10, 5, 0, 26);
    set_in(3, 1'b1, f); chk_ready("R10 tail", 5'b00000); tick();
    chk_none("R10 tail");
    clr();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule